// File: doc/BRIEF.md
# Dual-View Planar Frame Buffer Port

This block is the bus-facing access unit of an eight-plane indexed-colour frame buffer. Each bank stores one 8-bit colour index per pixel. A bus master can reach that storage in two ways. The planar view gives one 16-bit word per plane for every run of 16 neighbouring pixels. The pixel view gives one byte per pixel. Both views address the same storage, so a write through one view is seen at once through the other.

Two banks, A and B, hold two complete images. Reads on the bus come from the bank that one control input selects. Writes go to every bank that is not inhibited, so both banks can be updated in a single cycle. An 8-bit plane mask protects individual planes from writes and reads them back as zero.

A separate display read port returns whole pixels from a bank that has its own select input. Software can draw into one bank while the other is shown, and then swap the two by changing one bit. The number of pixels per bank is set by a parameter. A full 1152 by 900 screen fits in 2^20 pixels; the default is small.

Top module: `fbp_dual_view`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `bus_rvalid`, `bus_rdata` and `disp_pix` are all zero.
- R2: A read request (`bus_req`=1, `bus_we`=0) makes `bus_rvalid` high in the next cycle, with its data on `bus_rdata`. In any other cycle `bus_rvalid` is low.
- R3: When `bus_addr` MSB=0 the planar view is selected. The next three bits give the plane, and the low PIX_AW-4 bits give the word index. Bit 15 of the word is pixel word_index*16 and bit 0 is pixel word_index*16+15, so the leftmost pixel is at the MSB.
- R4: When `bus_addr` MSB=1 the pixel view is selected. Word w holds pixel 2w in bits 15:8 and pixel 2w+1 in bits 7:0. Bit p of each byte is plane p.
- R5: Data written through either view reads back correctly through the other view.
- R6: On a write, `bus_be[1]` enables bits 15:8 and `bus_be[0]` enables bits 7:0. A lane whose strobe is clear leaves its storage unchanged.
- R7: A write does not change a plane whose `plane_mask` bit is clear.
- R8: A plane whose `plane_mask` bit is clear reads as zero in both views.
- R9: `rd_bank_b`=0 selects bank A for bus reads and `rd_bank_b`=1 selects bank B.
- R10: `wr_inh_a` blocks writes to bank A and `wr_inh_b` blocks writes to bank B. With neither bit set, a write updates both banks.
- R11: One cycle after `disp_addr` is presented, `disp_pix` holds that pixel's full 8-bit value. It comes from bank B if `disp_bank_b`=1 and from bank A otherwise, and `plane_mask` has no effect on it.
- R12: A read issued in the cycle right after a write returns the data that write stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus request valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | PIX_AW | Word address; MSB selects the view |
| bus_wdata | input | 16 | Write data |
| bus_be | input | 2 | Byte lane strobes (bit 1 = bits 15:8) |
| bus_rdata | output | 16 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid |
| plane_mask | input | 8 | Per-plane access enable |
| rd_bank_b | input | 1 | Bus read bank: 1 = B |
| wr_inh_a | input | 1 | Block writes to bank A |
| wr_inh_b | input | 1 | Block writes to bank B |
| disp_bank_b | input | 1 | Display bank: 1 = B |
| disp_addr | input | PIX_AW | Display pixel index |
| disp_pix | output | 8 | Display pixel value |

## Verification
The assertions assume at most one request per cycle, either a read or a write. They also assume that `plane_mask` and the bank controls, as seen in a request's cycle, are the values that govern that request. The stimulus meets this by changing inputs only on falling clock edges. Control bits change only in idle cycles, and every address stays inside the two views. Storage has no reset, so the bench writes every pixel of both banks before it compares any read.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
    localparam int NPLANES = 8;
    localparam int WORD_W  = 16;

    typedef enum logic { WIN_PLANAR = 1'b0, WIN_PIXEL = 1'b1 } win_e;

    typedef logic [WORD_W-1:0]  pword_t;
    typedef logic [NPLANES-1:0] pix_t;

    // Bit-granular write to one planar word
    typedef struct packed {
        pword_t en;
        pword_t val;
    } bitwr_t;

    // Planar bit that holds the left pixel of pixel pair 'sub' within a word
    function automatic logic [3:0] pair_hi_bit(input logic [2:0] sub);
        return 4'd15 - {sub, 1'b0};
    endfunction

    // Planar bit that holds the pixel in column 'col' of a 16-pixel run
    function automatic logic [3:0] col_bit(input logic [3:0] col);
        return 4'd15 - col;
    endfunction
endpackage

// File: rtl/fbp_req_dec.sv
// Turns one bus request into a word index and per-plane bit writes.
module fbp_req_dec
    import fbp_pkg::*;
#(
    parameter int PIX_AW = 10
) (
    input  logic [PIX_AW-1:0]       bus_addr,
    input  pword_t                  bus_wdata,
    input  logic [1:0]              bus_be,
    input  pix_t                    plane_mask,
    output win_e                    win,
    output logic [PIX_AW-5:0]       word_idx,
    output logic [2:0]              plane_idx,
    output logic [2:0]              sub,
    output bitwr_t [NPLANES-1:0]    wr
);
    localparam int WIDX_W = PIX_AW - 4;

    pword_t     lane_en;
    logic [3:0] hb;
    logic [3:0] lb;

    always_comb begin
        win       = win_e'(bus_addr[PIX_AW-1]);
        plane_idx = bus_addr[PIX_AW-2 -: 3];
        sub       = bus_addr[2:0];
        word_idx  = (win == WIN_PIXEL) ? bus_addr[PIX_AW-2:3] : bus_addr[WIDX_W-1:0];
        lane_en   = {{8{bus_be[1]}}, {8{bus_be[0]}}};
        hb        = pair_hi_bit(sub);
        lb        = hb - 4'd1;
        for (int p = 0; p < NPLANES; p++) begin
            wr[p] = '0;
            if (plane_mask[p]) begin
                if (win == WIN_PLANAR) begin
                    if (plane_idx == 3'(p)) begin
                        wr[p].en  = lane_en;
                        wr[p].val = bus_wdata;
                    end
                end else begin
                    wr[p].en[hb]  = bus_be[1];
                    wr[p].val[hb] = bus_wdata[8+p];
                    wr[p].en[lb]  = bus_be[0];
                    wr[p].val[lb] = bus_wdata[p];
                end
            end
        end
    end
endmodule

// File: rtl/fbp_plane_mem.sv
// One plane of one bank: bit-write storage, two combinational read ports.
module fbp_plane_mem
    import fbp_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  bitwr_t        wr,
    input  logic [AW-1:0] raddr_bus,
    output pword_t        rdata_bus,
    input  logic [AW-1:0] raddr_disp,
    output pword_t        rdata_disp
);
    localparam int DEPTH = 1 << AW;

    pword_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= (mem[waddr] & ~wr.en) | (wr.val & wr.en);
        end
    end

    assign rdata_bus  = mem[raddr_bus];
    assign rdata_disp = mem[raddr_disp];
endmodule

// File: rtl/fbp_rd_fmt.sv
// Shapes the planar words of the read bank into the requested view.
module fbp_rd_fmt
    import fbp_pkg::*;
(
    input  win_e                             win,
    input  logic [2:0]                       plane_idx,
    input  logic [2:0]                       sub,
    input  pix_t                             plane_mask,
    input  logic [NPLANES-1:0][WORD_W-1:0]   words,
    output pword_t                           rdata
);
    logic [3:0] hb;
    logic [3:0] lb;

    always_comb begin
        rdata = '0;
        hb    = pair_hi_bit(sub);
        lb    = hb - 4'd1;
        if (win == WIN_PLANAR) begin
            if (plane_mask[plane_idx]) begin
                rdata = words[plane_idx];
            end
        end else begin
            for (int p = 0; p < NPLANES; p++) begin
                rdata[8+p] = plane_mask[p] & words[p][hb];
                rdata[p]   = plane_mask[p] & words[p][lb];
            end
        end
    end
endmodule

// File: rtl/fbp_dual_view.sv
// Dual-view planar frame buffer port: planar and pixel views, A/B banks.
module fbp_dual_view
    import fbp_pkg::*;
#(
    parameter int PIX_AW = 10   // log2 of pixels per bank (2^20 for full screen)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [PIX_AW-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic [1:0]        bus_be,
    output logic [15:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic [7:0]        plane_mask,
    input  logic              rd_bank_b,
    input  logic              wr_inh_a,
    input  logic              wr_inh_b,
    input  logic              disp_bank_b,
    input  logic [PIX_AW-1:0] disp_addr,
    output logic [7:0]        disp_pix
);
    localparam int WIDX_W = PIX_AW - 4;
    localparam int NBANKS = 2;

    win_e                           dec_win;
    logic [WIDX_W-1:0]              dec_widx;
    logic [2:0]                     dec_plane;
    logic [2:0]                     dec_sub;
    bitwr_t [NPLANES-1:0]           dec_wr;
    logic [NBANKS-1:0]              bank_we;
    logic [NBANKS-1:0]              bank_inh;
    pword_t                         bus_words  [NBANKS][NPLANES];
    pword_t                         disp_words [NBANKS][NPLANES];
    logic [NPLANES-1:0][WORD_W-1:0] rd_words;
    pword_t                         rdata_nx;
    pix_t                           disp_nx;
    logic                           rd_fire;

    fbp_req_dec #(.PIX_AW(PIX_AW)) u_dec (
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_be     (bus_be),
        .plane_mask (plane_mask),
        .win        (dec_win),
        .word_idx   (dec_widx),
        .plane_idx  (dec_plane),
        .sub        (dec_sub),
        .wr         (dec_wr)
    );

    assign bank_inh = {wr_inh_b, wr_inh_a};
    assign rd_fire  = bus_req & ~bus_we;

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        assign bank_we[b] = bus_req & bus_we & ~bank_inh[b];
        for (genvar p = 0; p < NPLANES; p++) begin : g_plane
            fbp_plane_mem #(.AW(WIDX_W)) u_mem (
                .clk        (clk),
                .we         (bank_we[b]),
                .waddr      (dec_widx),
                .wr         (dec_wr[p]),
                .raddr_bus  (dec_widx),
                .rdata_bus  (bus_words[b][p]),
                .raddr_disp (disp_addr[PIX_AW-1:4]),
                .rdata_disp (disp_words[b][p])
            );
        end
    end

    always_comb begin
        for (int p = 0; p < NPLANES; p++) begin
            rd_words[p] = rd_bank_b ? bus_words[1][p] : bus_words[0][p];
        end
    end

    fbp_rd_fmt u_fmt (
        .win        (dec_win),
        .plane_idx  (dec_plane),
        .sub        (dec_sub),
        .plane_mask (plane_mask),
        .words      (rd_words),
        .rdata      (rdata_nx)
    );

    always_comb begin
        for (int p = 0; p < NPLANES; p++) begin
            disp_nx[p] = disp_bank_b ? disp_words[1][p][col_bit(disp_addr[3:0])]
                                     : disp_words[0][p][col_bit(disp_addr[3:0])];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
            disp_pix   <= '0;
        end else begin
            bus_rvalid <= rd_fire;
            if (rd_fire) begin
                bus_rdata <= rdata_nx;
            end
            disp_pix <= disp_nx;
        end
    end
endmodule

// File: rtl/fbp_dual_view_chk.sv
module fbp_dual_view_chk #(
    parameter int PIX_AW = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic              bus_we,
    input logic [PIX_AW-1:0] bus_addr,
    input logic [15:0]       bus_rdata,
    input logic              bus_rvalid,
    input logic [7:0]        plane_mask,
    input logic [7:0]        disp_pix
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!bus_rvalid && bus_rdata == 16'h0 && disp_pix == 8'h0));

    // R2
    rvalid_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we) |=> bus_rvalid);

    // R2
    no_stray_rvalid_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_req && !bus_we) |=> !bus_rvalid);

    // R8
    planar_masked_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && !bus_addr[PIX_AW-1] && !plane_mask[bus_addr[PIX_AW-2 -: 3]])
        |=> (bus_rdata == 16'h0));

    // R8
    pixel_masked_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && bus_addr[PIX_AW-1])
        |=> ((bus_rdata & ~{$past(plane_mask), $past(plane_mask)}) == 16'h0));
endmodule

bind fbp_dual_view fbp_dual_view_chk #(.PIX_AW(PIX_AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .plane_mask (plane_mask),
    .disp_pix   (disp_pix)
);

// File: tb/fbp_dual_view_bench.sv
module fbp_dual_view_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PIX_AW     = 8;
    localparam int NPIX       = 1 << PIX_AW;
    localparam int NPW        = NPIX / 2;   // words in pixel view
    localparam int WPP        = NPIX / 16;  // planar words per plane

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [PIX_AW-1:0] bus_addr = '0;
    logic [15:0]       bus_wdata = '0;
    logic [1:0]        bus_be = '0;
    logic [15:0]       bus_rdata;
    logic              bus_rvalid;
    logic [7:0]        plane_mask = 8'hFF;
    logic              rd_bank_b = 1'b0;
    logic              wr_inh_a = 1'b0;
    logic              wr_inh_b = 1'b0;
    logic              disp_bank_b = 1'b0;
    logic [PIX_AW-1:0] disp_addr = '0;
    logic [7:0]        disp_pix;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0]  mdl [2][NPIX];
    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fbp_dual_view #(.PIX_AW(PIX_AW)) u_fbp_dual_view (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .plane_mask(plane_mask), .rd_bank_b(rd_bank_b),
        .wr_inh_a(wr_inh_a), .wr_inh_b(wr_inh_b),
        .disp_bank_b(disp_bank_b), .disp_addr(disp_addr), .disp_pix(disp_pix)
    );

    function automatic logic [PIX_AW-1:0] pix_addr(input int w);
        return {1'b1, (PIX_AW-1)'(w)};
    endfunction

    function automatic logic [PIX_AW-1:0] pln_addr(input int pl, input int wi);
        return {1'b0, 3'(pl), (PIX_AW-4)'(wi)};
    endfunction

    // Expected read value from R3, R4, R8
    function automatic logic [15:0] model_read(input logic [PIX_AW-1:0] a,
                                               input int bk, input logic [7:0] m);
        logic [15:0] r;
        int w, pl, wi;
        r = '0;
        if (a[PIX_AW-1]) begin
            w = int'(a[PIX_AW-2:0]);
            r = {mdl[bk][2*w] & m, mdl[bk][2*w+1] & m};
        end else begin
            pl = int'(a[PIX_AW-2 -: 3]);
            wi = int'(a[PIX_AW-5:0]);
            for (int b = 0; b < 16; b++) r[b] = m[pl] & mdl[bk][wi*16 + 15 - b][pl];
        end
        return r;
    endfunction

    // Store update from R3, R4, R6, R7
    function automatic void model_write(input int bk, input logic [PIX_AW-1:0] a,
                                        input logic [15:0] d, input logic [1:0] be,
                                        input logic [7:0] m);
        int w, pl, wi;
        if (a[PIX_AW-1]) begin
            w = int'(a[PIX_AW-2:0]);
            for (int p = 0; p < 8; p++) begin
                if (m[p] && be[1]) mdl[bk][2*w][p]   = d[8+p];
                if (m[p] && be[0]) mdl[bk][2*w+1][p] = d[p];
            end
        end else begin
            pl = int'(a[PIX_AW-2 -: 3]);
            wi = int'(a[PIX_AW-5:0]);
            for (int b = 0; b < 16; b++)
                if (m[pl] && be[b/8]) mdl[bk][wi*16 + 15 - b][pl] = d[b];
        end
    endfunction

    task automatic check(input logic ok, input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_ctrl(input logic [7:0] m, input logic rb, input logic ia,
                            input logic ib);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        plane_mask = m; rd_bank_b = rb; wr_inh_a = ia; wr_inh_b = ib;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_req = 1'b0; bus_we = 1'b0;
        end
    endtask

    // Driver: one write, one cycle
    task automatic bus_write(input logic [PIX_AW-1:0] a, input logic [15:0] d,
                             input logic [1:0] be);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        if (!wr_inh_a) model_write(0, a, d, be, plane_mask);
        if (!wr_inh_b) model_write(1, a, d, be, plane_mask);
    endtask

    // Driver: one read, expected value pushed to scoreboard
    task automatic bus_read(input logic [PIX_AW-1:0] a, input string tag);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        exp_q.push_back(model_read(a, rd_bank_b ? 1 : 0, plane_mask));
        tag_q.push_back(tag);
    endtask

    task automatic disp_check(input int pix, input logic bk, input string tag);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        disp_addr = PIX_AW'(pix); disp_bank_b = bk;
        @(negedge clk);
        check(disp_pix == mdl[bk ? 1 : 0][pix], tag, {8'h0, disp_pix},
              {8'h0, mdl[bk ? 1 : 0][pix]});
    endtask

    // Monitor: compares each returned read with the scoreboard head
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 stray rvalid", bus_rdata, 16'h0);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(bus_rdata === e, t, bus_rdata, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(bus_rvalid == 1'b0, "R1 rvalid", {15'h0, bus_rvalid}, 16'h0);
        check(bus_rdata == 16'h0, "R1 rdata", bus_rdata, 16'h0);
        check(disp_pix == 8'h0, "R1 disp_pix", {8'h0, disp_pix}, 16'h0);
        rst = 1'b0;

        // Fill both banks through the pixel view (R10 neither inhibited)
        for (int w = 0; w < NPW; w++)
            bus_write(pix_addr(w), {8'(2*w*37 + 5), 8'((2*w+1)*37 + 5)}, 2'b11);
        for (int w = 0; w < NPW; w++) bus_read(pix_addr(w), "R4 pixel view bank A");
        set_ctrl(8'hFF, 1'b1, 1'b0, 1'b0);
        for (int w = 0; w < NPW; w += 3) bus_read(pix_addr(w), "R10 both banks written");
        set_ctrl(8'hFF, 1'b0, 1'b0, 1'b0);
        for (int pl = 0; pl < 8; pl++)
            for (int wi = 0; wi < WPP; wi++)
                bus_read(pln_addr(pl, wi), "R5 planar view of pixel writes");

        // Planar writes, checked through the pixel view (R3, R5)
        for (int pl = 0; pl < 8; pl++)
            for (int wi = 0; wi < WPP; wi++)
                bus_write(pln_addr(pl, wi), 16'((pl*4099 + wi*771) ^ 16'hA5C3), 2'b11);
        bus_write(pln_addr(0, 0), 16'h8000, 2'b11);
        bus_write(pln_addr(7, WPP-1), 16'h0001, 2'b11);
        for (int w = 0; w < NPW; w++) bus_read(pix_addr(w), "R5 pixel view of planar writes");
        bus_read(pln_addr(0, 0), "R3 leftmost pixel at MSB");
        disp_check(0, 1'b0, "R3 pixel 0 from planar MSB");
        disp_check(NPIX-1, 1'b0, "R3 last pixel from planar LSB");

        // Byte strobes (R6)
        bus_write(pln_addr(2, 1), 16'hFFFF, 2'b01);
        bus_write(pln_addr(5, 3), 16'h0000, 2'b10);
        bus_write(pix_addr(9), 16'h1234, 2'b10);
        bus_write(pix_addr(10), 16'hABCD, 2'b01);
        bus_write(pix_addr(11), 16'h5A5A, 2'b00);
        bus_read(pln_addr(2, 1), "R6 planar low lane only");
        bus_read(pln_addr(5, 3), "R6 planar high lane only");
        bus_read(pix_addr(9), "R6 pixel high lane only");
        bus_read(pix_addr(10), "R6 pixel low lane only");
        bus_read(pix_addr(11), "R6 no strobe");

        // Plane mask on writes (R7) and reads (R8)
        set_ctrl(8'h0F, 1'b0, 1'b0, 1'b0);
        bus_write(pix_addr(20), 16'hFFFF, 2'b11);
        bus_write(pix_addr(21), 16'h0000, 2'b11);
        bus_write(pln_addr(6, 2), 16'hFFFF, 2'b11);
        bus_write(pln_addr(1, 2), 16'h0F0F, 2'b11);
        set_ctrl(8'hFF, 1'b0, 1'b0, 1'b0);
        bus_read(pix_addr(20), "R7 masked planes kept");
        bus_read(pix_addr(21), "R7 masked planes kept");
        bus_read(pln_addr(6, 2), "R7 masked plane write dropped");
        bus_read(pln_addr(1, 2), "R7 enabled plane written");
        set_ctrl(8'h0F, 1'b0, 1'b0, 1'b0);
        bus_read(pix_addr(20), "R8 pixel masked zero");
        bus_read(pix_addr(33), "R8 pixel masked zero");
        bus_read(pln_addr(6, 2), "R8 planar masked zero");
        bus_read(pln_addr(3, 2), "R8 planar unmasked");
        set_ctrl(8'h00, 1'b0, 1'b0, 1'b0);
        bus_read(pix_addr(40), "R8 all masked");

        // Write inhibit (R10) and read bank select (R9)
        set_ctrl(8'hFF, 1'b0, 1'b1, 1'b0);
        bus_write(pix_addr(50), 16'hC3E1, 2'b11);
        bus_write(pln_addr(4, 5), 16'h9999, 2'b11);
        set_ctrl(8'hFF, 1'b0, 1'b0, 1'b1);
        bus_write(pix_addr(51), 16'h7E11, 2'b11);
        set_ctrl(8'hFF, 1'b0, 1'b1, 1'b1);
        bus_write(pix_addr(52), 16'h0F0F, 2'b11);
        set_ctrl(8'hFF, 1'b0, 1'b0, 1'b0);
        for (int w = 50; w < 53; w++) bus_read(pix_addr(w), "R10 bank A after inhibits");
        bus_read(pln_addr(4, 5), "R10 bank A inhibited planar");
        set_ctrl(8'hFF, 1'b1, 1'b0, 1'b0);
        for (int w = 50; w < 53; w++) bus_read(pix_addr(w), "R9 bank B read");
        bus_read(pln_addr(4, 5), "R9 bank B planar read");

        // Display port (R11), mask has no effect on it
        set_ctrl(8'h00, 1'b0, 1'b0, 1'b0);
        disp_check(100, 1'b0, "R11 disp bank A");
        disp_check(100, 1'b1, "R11 disp bank B");
        disp_check(102, 1'b0, "R11 disp bank A");
        disp_check(102, 1'b1, "R11 disp bank B");
        disp_check(15, 1'b1, "R11 disp column 15");
        disp_check(16, 1'b0, "R11 disp column 0");

        // Read right after write (R12)
        set_ctrl(8'hFF, 1'b0, 1'b0, 1'b0);
        bus_write(pix_addr(60), 16'h3C96, 2'b11);
        bus_read(pix_addr(60), "R12 read after write");
        bus_write(pln_addr(3, 7), 16'hE71B, 2'b11);
        bus_read(pix_addr(60), "R12 alias read after planar write");
        bus_read(pln_addr(3, 7), "R12 planar read");
        idle(4);
        check(exp_q.size() == 0, "R2 reads outstanding", 16'(exp_q.size()), 16'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule